// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block links a synchronous on-chip master to an external asynchronous static RAM that is 8 bits wide. It carries out one byte read or one byte write per request. The master raises `req` while `ready` is high. On that clock edge the block takes in the address, the write flag and the write byte. It then drives the memory's active-low strobes through a timed sequence and returns to idle. A read ends with the captured byte on `rdata` and a one-cycle `rvalid` pulse.

All timing is met by counting clock cycles, and the block needs no delay lines. Each minimum interval of the memory is a parameter in nanoseconds. Each one is turned into a cycle count by rounding up against `CLK_NS`. Every memory-side output comes straight from a flop, so strobes and address change only on clock edges and cannot glitch. The bidirectional data bus is split into an output byte, an input byte and a drive enable. The pad ring joins them.

The controller drives the bus only during a write, and only after the memory's output-disable delay has passed since the last read.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever `ready` is high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0.
- R2: A request is accepted only on a clock edge where `ready` is high. While `ready` is low, changes on `req`, `addr` and `wr` have no effect on the memory-side outputs.
- R3: A write (`wr`=1) drives `mem_ce_n` and `mem_we_n` low together for exactly WA = ceil(max(55,60,60,30)/CLK_NS) cycles. For the whole write, `mem_oe_n` stays 1 and `mem_dq_oe`=1 with `mem_dq_o` equal to the accepted byte. The write ends when both strobes rise on the same edge.
- R4: `mem_addr` is loaded on acceptance and holds steady for as long as `mem_ce_n` is 0.
- R5: A read (`wr`=0) drives `mem_ce_n` and `mem_oe_n` low together for exactly RA = ceil(max(70,35)/CLK_NS) cycles. During a read `mem_we_n` is 1 and `mem_dq_oe` is 0. Both strobes rise together on the edge that captures `mem_dq_i`.
- R6: On the edge that ends a read, `rdata` takes the byte on `mem_dq_i` and `rvalid` is high for exactly one cycle. `rdata` keeps its value until the next read ends.
- R7: After a write is accepted, `ready` stays low for WA + max(1, ceil(70/CLK_NS) − WA) cycles. This keeps consecutive address changes at least 70 ns apart.
- R8: After a read is accepted, `ready` stays low for RA + max(1, ceil(25/CLK_NS)) cycles. The bus driver is therefore never enabled within 25 ns of `mem_oe_n` rising.
- R9: `mem_oe_n` and `mem_we_n` are never low at the same time. `mem_dq_oe` is 1 only while `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1.
- R10: A byte read from any address equals the last byte written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS ns |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| ready | output | 1 | Idle; a request is accepted this edge |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address |
| wdata | input | DW | Write byte |
| rdata | output | DW | Captured read byte |
| rvalid | output | 1 | One-cycle pulse when `rdata` is new |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Data toward the memory |
| mem_dq_i | input | DW | Data from the memory bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |

## Verification
Several properties are checked by assertions on every clock edge:
- the strobe encoding rules;
- the restriction of bus driving to the write phase;
- the address holding steady while the chip is selected;
- the exact number of cycles the chip enable stays low for each access kind;
- the single-cycle read-valid pulse.

Other behaviour appears only across whole scenarios. This covers data integrity over a sweep of every address in a reduced configuration, followed by a mixed random phase. It also covers the nanosecond intervals the memory model measures between edges: write pulse, chip-select and address windows, data setup, cycle time, read access, and bus turnaround after a read. Finally, the scenarios show that a request held high during a busy access is ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_REC  = 2'd2
   } sc_state_e;

   // Cycles needed to cover ns nanoseconds at a period of per ns.
   function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Remaining cycles of a total once an active phase is spent, at least one.
   function automatic int unsigned rest_of(input int unsigned total, input int unsigned used);
      return (total > used + 1) ? (total - used) : 1;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (ld)
         cnt <= ld_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R7
   timer_reload_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ld && ld_val != '0) |=> !done);

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          stop,
   input  logic          start_wr,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_data,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n,
   output logic [AW-1:0] maddr,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
         maddr <= '0;
         dq_o  <= '0;
      end else if (start) begin
         maddr <= start_addr;
         dq_o  <= start_data;
         ce_n  <= 1'b0;
         we_n  <= !start_wr;
         oe_n  <= start_wr;
         dq_oe <= start_wr;
      end else if (stop) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end
   end

   // R9
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!oe_n && !we_n));

   // R9
   drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
      dq_oe |-> (!ce_n && !we_n && oe_n));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && $past(!ce_n)) |-> $stable(maddr));

   // R3
   we_ce_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n) |-> $rose(ce_n));

   // R5
   oe_ce_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(oe_n) |-> $rose(ce_n));

endmodule

// File: rtl/sram_ctl_rcap.sv
module sram_ctl_rcap #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= cap;
         if (cap)
            rdata <= din;
      end
   end

   // R6
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid |=> !rvalid);

   // R6
   rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !cap |=> $stable(rdata));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int CLK_NS   = 4,
   parameter int AW       = 15,
   parameter int DW       = 8,
   parameter int T_WP_NS  = 55,
   parameter int T_CW_NS  = 60,
   parameter int T_AW_NS  = 60,
   parameter int T_DS_NS  = 30,
   parameter int T_WC_NS  = 70,
   parameter int T_AA_NS  = 70,
   parameter int T_OA_NS  = 35,
   parameter int T_RC_NS  = 70,
   parameter int T_OZ_NS  = 25
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   output logic          ready,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   input  logic [DW-1:0] mem_dq_i,
   output logic          mem_dq_oe
);

   localparam int unsigned PER   = CLK_NS;
   localparam int unsigned W_ACT = maxu(maxu(cyc_of(T_WP_NS, PER), cyc_of(T_CW_NS, PER)),
                                        maxu(cyc_of(T_AW_NS, PER), cyc_of(T_DS_NS, PER)));
   localparam int unsigned W_REC = rest_of(cyc_of(T_WC_NS, PER), W_ACT);
   localparam int unsigned R_ACT = maxu(maxu(cyc_of(T_AA_NS, PER), cyc_of(T_OA_NS, PER)),
                                        cyc_of(T_RC_NS, PER));
   localparam int unsigned R_REC = maxu(1, cyc_of(T_OZ_NS, PER));
   localparam int unsigned C_MAX = maxu(maxu(W_ACT, W_REC), maxu(R_ACT, R_REC));
   localparam int CW = $clog2(C_MAX + 1);

   localparam logic [CW-1:0] W_ACT_M1 = CW'(W_ACT - 1);
   localparam logic [CW-1:0] W_REC_M1 = CW'(W_REC - 1);
   localparam logic [CW-1:0] R_ACT_M1 = CW'(R_ACT - 1);
   localparam logic [CW-1:0] R_REC_M1 = CW'(R_REC - 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_ctl: CLK_NS must be at least 1");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_ctl: AW and DW must be positive");
      end
      if (W_ACT < 1 || R_ACT < 1) begin : g_bad_timing
         $error("sram_ctl: active phases need at least one cycle");
      end
   endgenerate

   sc_state_e     st;
   logic          is_wr;
   logic          t_done;
   logic          t_ld;
   logic [CW-1:0] t_val;
   logic          start;
   logic          stop;

   assign ready = (st == ST_IDLE);
   assign start = ready && req;
   assign stop  = (st == ST_ACT) && t_done;
   assign t_ld  = start || stop;

   always_comb begin
      if (start)
         t_val = wr ? W_ACT_M1 : R_ACT_M1;
      else
         t_val = is_wr ? W_REC_M1 : R_REC_M1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_IDLE;
         is_wr <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (req) begin
               st    <= ST_ACT;
               is_wr <= wr;
            end
            ST_ACT:  if (t_done) st <= ST_REC;
            ST_REC:  if (t_done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   sram_ctl_timer #(.CW(CW)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .ld     (t_ld),
      .ld_val (t_val),
      .done   (t_done)
   );

   sram_ctl_pins #(.AW(AW), .DW(DW)) u_pins (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .stop       (stop),
      .start_wr   (wr),
      .start_addr (addr),
      .start_data (wdata),
      .ce_n       (mem_ce_n),
      .oe_n       (mem_oe_n),
      .we_n       (mem_we_n),
      .maddr      (mem_addr),
      .dq_o       (mem_dq_o),
      .dq_oe      (mem_dq_oe)
   );

   sram_ctl_rcap #(.DW(DW)) u_rcap (
      .clk    (clk),
      .rst    (rst),
      .cap    (stop && !is_wr),
      .din    (mem_dq_i),
      .rdata  (rdata),
      .rvalid (rvalid)
   );

   // Cycles the chip enable has spent low, kept apart from the sequencer.
   logic [CW-1:0] low_cnt;
   always_ff @(posedge clk) begin
      if (rst || mem_ce_n)
         low_cnt <= '0;
      else if (low_cnt != '1)
         low_cnt <= low_cnt + 1'b1;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

   // R2
   start_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_ce_n) |-> $past(ready));

   // R3 and R5: selected phase length by access kind
   select_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_ce_n) |-> (low_cnt == ($past(mem_we_n) ? CW'(R_ACT) : CW'(W_ACT))));

   // R6
   rvalid_on_release_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> ($rose(mem_oe_n) && mem_ce_n));

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

   localparam int AW     = 10;
   localparam int DW     = 8;
   localparam int CLK_NS = 4;
   localparam int DEPTH  = 1 << AW;

   function automatic int cdiv(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction

   // Expected cycle counts, derived here from the requirements.
   localparam int EWA   = (cdiv(60) > cdiv(55)) ? cdiv(60) : cdiv(55);
   localparam int EWBSY = (cdiv(70) - EWA > 1) ? cdiv(70) : EWA + 1;
   localparam int ERA   = cdiv(70);
   localparam int ERBSY = ERA + ((cdiv(25) > 1) ? cdiv(25) : 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          ready, rvalid;
   logic [DW-1:0] rdata;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   sram_ctl #(.CLK_NS(CLK_NS), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
      .mem_dq_oe(mem_dq_oe)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory ----------------
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] refm [DEPTH];
   logic [DW-1:0] wbuf = '0;
   wire  mread = !mem_ce_n && !mem_oe_n && mem_we_n;
   wire  wend  = mem_ce_n | mem_we_n;

   assign mem_dq_i = mread ? mem[mem_addr] : (mem_dq_oe ? mem_dq_o : 'z);

   always @(mem_dq_o or mem_dq_oe)
      if (mem_dq_oe) wbuf = mem_dq_o;

   always @(posedge wend)
      if (armed) mem[mem_addr] = wbuf;

   // ---------------- interval monitors ----------------
   bit   armed = 1'b0;
   longint t_we_fall = -1, t_ce_fall = -1, t_addr = -1, t_drv = -1;
   longint t_oe_fall = -1, t_oe_rise = -1;

   always @(negedge mem_we_n) t_we_fall = $time;
   always @(negedge mem_ce_n) t_ce_fall = $time;
   always @(negedge mem_oe_n) t_oe_fall = $time;

   always @(mem_addr) begin
      if (armed && t_addr >= 0)
         chk(($time - t_addr) >= 70, "R7 address change spacing ns", int'($time - t_addr), 70);
      t_addr = $time;
   end

   always @(posedge mem_dq_oe) begin
      t_drv = $time;
      if (armed) begin
         chk(mem_oe_n === 1'b1, "R8 oe high when driving", int'(mem_oe_n), 1);
         if (t_oe_rise >= 0)
            chk(($time - t_oe_rise) >= 25, "R8 turnaround ns", int'($time - t_oe_rise), 25);
      end
   end

   always @(posedge mem_we_n) begin
      if (armed && t_we_fall >= 0) begin
         chk(($time - t_we_fall) >= 55, "R3 write pulse ns", int'($time - t_we_fall), 55);
         chk(($time - t_ce_fall) >= 60, "R3 select to write end ns", int'($time - t_ce_fall), 60);
         chk(($time - t_addr) >= 60, "R3 address to write end ns", int'($time - t_addr), 60);
         chk(($time - t_drv) >= 30, "R3 data setup ns", int'($time - t_drv), 30);
      end
   end

   always @(posedge mem_oe_n) begin
      if (armed && t_oe_fall >= 0) begin
         t_oe_rise = $time;
         chk(($time - t_oe_fall) >= 70, "R5 read access ns", int'($time - t_oe_fall), 70);
      end
   end

   // ---------------- one access ----------------
   task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit hold);
      int busy = 0, celo = 0, oelo = 0, welo = 0, nval = 0;
      bit addrbad = 0, drvbad = 0, done = 0;
      logic [DW-1:0] rd = '0;
      @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      @(posedge clk);
      while (!done) begin
         @(negedge clk);
         if (hold) begin addr = ~a; wr = ~w; end
         else req = 1'b0;
         if (ready) done = 1;
         else begin
            busy++;
            if (!mem_ce_n) celo++;
            if (!mem_oe_n) oelo++;
            if (!mem_we_n) welo++;
            if (!mem_ce_n && mem_addr != a) addrbad = 1;
            if (w && !mem_ce_n && (!mem_dq_oe || mem_dq_o != d)) drvbad = 1;
            if (!w && mem_dq_oe) drvbad = 1;
            if (rvalid) begin nval++; rd = rdata; end
         end
      end
      req = 1'b0;
      chk(!addrbad, "R4 address held while selected", int'(addrbad), 0);
      if (hold) chk(!addrbad && celo == (w ? EWA : ERA), "R2 held request ignored while busy",
                    celo, w ? EWA : ERA);
      if (w) begin
         chk(busy == EWBSY, "R7 write busy cycles", busy, EWBSY);
         chk(celo == EWA && welo == EWA, "R3 ce/we low cycles", welo, EWA);
         chk(oelo == 0 && !drvbad, "R3 oe high and data driven", oelo, 0);
         refm[a] = d;
      end else begin
         chk(busy == ERBSY, "R8 read busy cycles", busy, ERBSY);
         chk(celo == ERA && oelo == ERA, "R5 ce/oe low cycles", oelo, ERA);
         chk(welo == 0 && !drvbad, "R5 we high and bus released", welo, 0);
         chk(nval == 1, "R6 single rvalid pulse", nval, 1);
         chk(rd == refm[a], "R10 read data", int'(rd), int'(refm[a]));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; refm[i] = '0; end
      repeat (4) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      armed = 1'b1;
      // R1: reset/idle state
      chk(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
      chk({mem_ce_n, mem_oe_n, mem_we_n} === 3'b111, "R1 strobes high", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
      chk(mem_dq_oe === 1'b0, "R1 bus released", int'(mem_dq_oe), 0);

      // R10: sweep every address, write then read in reverse
      for (int i = 0; i < DEPTH; i++)
         do_op(1'b1, AW'(i), DW'((i * 37 + 11) ^ (i >> 8)), 1'b0);
      for (int i = DEPTH - 1; i >= 0; i--)
         do_op(1'b0, AW'(i), '0, 1'b0);

      // Mixed random phase: back-to-back read/write turnarounds
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_op(lf[0], AW'(lf[15:6]), DW'(lf[7:0] ^ lf[15:8]), 1'b0);
      end

      // R2: request held high across a busy access
      do_op(1'b1, AW'(5), 8'h5A, 1'b1);
      do_op(1'b0, AW'(5), '0, 1'b1);
      do_op(1'b0, AW'(DEPTH - 1), '0, 1'b0);

      @(negedge clk);
      chk(ready === 1'b1 && mem_ce_n === 1'b1, "R1 idle at end", int'(ready), 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule